// File: doc/BRIEF.md
# Integer ALU with Operand Inversion Controls

This block is the 32-bit integer arithmetic and logic unit of a simple RISC-style datapath. It is purely combinational. It takes two operands, a 3-bit operation code, an alternate-function bit, an invert-B bit and an add-one bit, and returns a result word and a zero flag. The operation code follows the usual 3-bit function field of a RISC-style integer instruction set, so the decoder can pass that field through unchanged.

There is no dedicated subtract code. The decoder asserts invert-B and add-one together with the add code, and the adder then computes A plus the complement of B plus one, which is A minus B. The same pair of controls with A held at zero negates B.

The two compare codes return 0 or 1. A branch unit reads only the zero flag to decide whether to branch. The compares always use the operand B exactly as presented, whatever the invert-B and add-one controls say.

Top module: `alu_core`

## Requirements
- R1: With op_i = 3'b000 and inv_b_i = add_one_i = 0, result_o equals (a_i + b_i) modulo 2^32.
- R2: When inv_b_i = 1, the bitwise complement of b_i replaces b_i as the second operand of the add code (3'b000) and of the logic codes (3'b100, 3'b110, 3'b111).
- R3: With op_i = 3'b000, add_one_i = 1 adds a carry-in of one; with inv_b_i = 1 as well, result_o equals a_i - b_i modulo 2^32. add_one_i has no effect on any other code.
- R4: op_i = 3'b010 gives result_o = 1 when a_i < b_i as signed two's-complement numbers, and 0 otherwise; bits 31..1 are 0.
- R5: op_i = 3'b011 gives result_o = 1 when a_i < b_i as unsigned numbers, and 0 otherwise; bits 31..1 are 0.
- R6: Codes 3'b010 and 3'b011 compare against the raw b_i, whatever the values of inv_b_i and add_one_i.
- R7: op_i = 3'b001 gives a_i shifted left by b_i[4:0], with zeros filling from the bottom; b_i[31:5] is ignored.
- R8: op_i = 3'b101 shifts a_i right by b_i[4:0]. With alt_i = 1, copies of a_i[31] fill from the top (arithmetic shift). With alt_i = 0, zeros fill from the top (logical shift).
- R9: op_i = 3'b100, 3'b110 and 3'b111 give the bitwise XOR, OR and AND of a_i and the second operand.
- R10: zero_o is 1 exactly when all 32 bits of result_o are 0.
- R11: alt_i has no effect on any code other than 3'b101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, and the shift amount in its low 5 bits |
| op_i | input | 3 | Operation code |
| alt_i | input | 1 | Alternate function: arithmetic right shift when high |
| inv_b_i | input | 1 | Complement the second operand of the add and logic codes |
| add_one_i | input | 1 | Carry-in of one for the add code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
Immediate assertions are evaluated on every input change. They check that the subtract form of the add code matches A minus B, that the compare unit agrees with signed and unsigned less-than, that compare results carry nothing above bit 0, and that an arithmetic right shift keeps the sign bit. The bench scenarios cover what the assertions do not. These are: the invert controls being ignored on compares and on the shift amount, the upper bits of b_i being ignored in shifts, alt_i being ignored on codes other than the right shift, the logic codes with an inverted operand, and the zero flag at carry wrap-around.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SLL  = 3'b001,
    OP_SLT  = 3'b010,
    OP_SLTU = 3'b011,
    OP_XOR  = 3'b100,
    OP_SRX  = 3'b101,
    OP_OR   = 3'b110,
    OP_AND  = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] full;

  always_comb begin
    full  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o = full[W-1:0];
  end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W:0] diff;
  logic       ovf;

  // Dedicated subtractor on raw B; borrow gives unsigned, sign^overflow gives signed.
  always_comb begin
    diff   = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
    ovf    = (a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ diff[W-1]);
    lt_u_o = ~diff[W];
    lt_s_o = diff[W-1] ^ ovf;
  end

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R5
      cmp_unsigned_chk: assert (lt_u_o == (a_i < b_i))
        else $error("unsigned compare mismatch");
      // R4
      cmp_signed_chk: assert (lt_s_o == ($signed(a_i) < $signed(b_i)))
        else $error("signed compare mismatch");
    end
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] shamt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] stage [SW+1];
  logic         fill;

  // Left shift is a right shift of the bit-reversed word.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i] = a_i[W-1-i];
  end

  assign fill     = arith_i & ~left_i & a_i[W-1];
  assign stage[0] = left_i ? rev_in : a_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned D = 1 << k;
    assign stage[k+1] = shamt_i[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
  end

  for (genvar i = 0; i < W; i++) begin : g_unrev
    assign rev_out[i] = stage[SW][W-1-i];
  end

  assign res_o = left_i ? rev_out : stage[SW];

  always_comb begin
    if (!$isunknown({a_i, shamt_i, left_i, arith_i})) begin
      // R8
      sra_sign_keep_chk: assert (!(arith_i && !left_i) || res_o[W-1] == a_i[W-1])
        else $error("arithmetic shift lost sign");
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  input  logic         alt_i,
  input  logic         inv_b_i,
  input  logic         add_one_i,
  output logic [W-1:0] result_o,
  output logic         zero_o
);
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic [W-1:0] sh_res;
  logic         lt_s;
  logic         lt_u;
  alu_op_e      op;

  assign op    = alu_op_e'(op_i);
  assign b_eff = inv_b_i ? ~b_i : b_i;

  alu_adder #(.W(W)) u_add (
    .a_i   (a_i),
    .b_i   (b_eff),
    .cin_i (add_one_i),
    .sum_o (sum)
  );

  // Compares see raw B so decoder invert controls never disturb branches.
  alu_cmp #(.W(W)) u_cmp (
    .a_i    (a_i),
    .b_i    (b_i),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  alu_shifter #(.W(W)) u_sh (
    .a_i     (a_i),
    .shamt_i (b_i[SW-1:0]),
    .left_i  (op == OP_SLL),
    .arith_i (alt_i),
    .res_o   (sh_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  result_o = sum;
      OP_SLL:  result_o = sh_res;
      OP_SLT:  result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: result_o = {{(W-1){1'b0}}, lt_u};
      OP_XOR:  result_o = a_i ^ b_eff;
      OP_SRX:  result_o = sh_res;
      OP_OR:   result_o = a_i | b_eff;
      OP_AND:  result_o = a_i & b_eff;
      default: result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i, inv_b_i, add_one_i})) begin
      // R3
      sub_result_chk: assert (!(op == OP_ADD && inv_b_i && add_one_i) || result_o == a_i - b_i)
        else $error("subtract form mismatch");
      // R4
      cmp_upper_zero_chk: assert (!(op == OP_SLT || op == OP_SLTU) || result_o[W-1:1] == '0)
        else $error("compare result has upper bits");
    end
  end
endmodule

// File: tb/alu_core_test.sv
module alu_core_test;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [2:0]  op;
  logic        alt, inv, add1;
  logic [31:0] result;
  logic        zero;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alu_core uut (
    .a_i(a), .b_i(b), .op_i(op), .alt_i(alt), .inv_b_i(inv), .add_one_i(add1),
    .result_o(result), .zero_o(zero)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ta, input logic [31:0] tb_, input logic [2:0] top,
                       input logic talt, input logic tinv, input logic tadd);
    @(negedge clk);
    a = ta; b = tb_; op = top; alt = talt; inv = tinv; add1 = tadd;
    @(posedge clk);
    #1;
  endtask

  task automatic t_idle;
    drive(32'h0, 32'h0, 3'b000, 1'b0, 1'b0, 1'b0);
    chk("R1 idle result", result, 32'h0);
    chk("R10 idle zero", {31'h0, zero}, 32'h1);
  endtask

  task automatic t_add;
    drive(32'h1234_5678, 32'h1111_1111, 3'b000, 1'b0, 1'b0, 1'b0);
    chk("R1 add", result, 32'h2345_6789);
    chk("R10 add nonzero", {31'h0, zero}, 32'h0);
    drive(32'hFFFF_FFFF, 32'h1, 3'b000, 1'b0, 1'b0, 1'b0);
    chk("R1 add wrap", result, 32'h0);
    chk("R10 wrap zero", {31'h0, zero}, 32'h1);
    drive(32'h1234_5678, 32'h1111_1111, 3'b000, 1'b1, 1'b0, 1'b0);
    chk("R11 alt on add", result, 32'h2345_6789);
  endtask

  task automatic t_sub;
    drive(32'd5, 32'd7, 3'b000, 1'b0, 1'b1, 1'b1);
    chk("R3 sub", result, 32'hFFFF_FFFE);
    drive(32'd0, 32'd9, 3'b000, 1'b0, 1'b1, 1'b1);
    chk("R3 negate", result, 32'hFFFF_FFF7);
    drive(32'd42, 32'd42, 3'b000, 1'b0, 1'b1, 1'b1);
    chk("R10 sub equal zero", {31'h0, zero}, 32'h1);
    drive(32'd10, 32'd3, 3'b000, 1'b0, 1'b1, 1'b0);
    chk("R2 add inverted", result, 32'd10 + ~32'd3);
    drive(32'd10, 32'd3, 3'b000, 1'b0, 1'b0, 1'b1);
    chk("R3 carry only", result, 32'd14);
  endtask

  task automatic t_cmp;
    drive(32'hFFFF_FFFF, 32'h1, 3'b010, 1'b0, 1'b0, 1'b0);
    chk("R4 -1<1", result, 32'h1);
    drive(32'h1, 32'hFFFF_FFFF, 3'b010, 1'b0, 1'b0, 1'b0);
    chk("R4 1<-1", result, 32'h0);
    drive(32'h8000_0000, 32'h7FFF_FFFF, 3'b010, 1'b0, 1'b0, 1'b0);
    chk("R4 min<max", result, 32'h1);
    drive(32'd7, 32'd7, 3'b010, 1'b0, 1'b0, 1'b0);
    chk("R4 equal", result, 32'h0);
    chk("R10 cmp false zero", {31'h0, zero}, 32'h1);
    drive(32'h8000_0000, 32'h7FFF_FFFF, 3'b011, 1'b0, 1'b0, 1'b0);
    chk("R5 unsigned big", result, 32'h0);
    drive(32'h1, 32'hFFFF_FFFF, 3'b011, 1'b0, 1'b0, 1'b0);
    chk("R5 unsigned small", result, 32'h1);
    drive(32'h1, 32'hFFFF_FFFF, 3'b011, 1'b0, 1'b1, 1'b1);
    chk("R6 sltu ignores inv", result, 32'h1);
    drive(32'hFFFF_FFFF, 32'h1, 3'b010, 1'b1, 1'b1, 1'b1);
    chk("R6 slt ignores inv", result, 32'h1);
    drive(32'h1, 32'hFFFF_FFFF, 3'b010, 1'b1, 1'b0, 1'b0);
    chk("R11 alt on slt", result, 32'h0);
  endtask

  task automatic t_shift;
    drive(32'h8000_0001, 32'h0, 3'b001, 1'b0, 1'b0, 1'b0);
    chk("R7 sll 0", result, 32'h8000_0001);
    drive(32'h0000_0003, 32'h25, 3'b001, 1'b0, 1'b0, 1'b0);
    chk("R7 sll upper b ignored", result, 32'h0000_0060);
    drive(32'h0000_0003, 32'd31, 3'b001, 1'b1, 1'b0, 1'b0);
    chk("R11 sll 31 alt", result, 32'h8000_0000);
    drive(32'h8000_0000, 32'd31, 3'b101, 1'b1, 1'b0, 1'b0);
    chk("R8 sra 31", result, 32'hFFFF_FFFF);
    drive(32'h8000_0000, 32'd31, 3'b101, 1'b0, 1'b0, 1'b0);
    chk("R8 srl 31", result, 32'h1);
    drive(32'hF000_00F0, 32'd4, 3'b101, 1'b1, 1'b0, 1'b0);
    chk("R8 sra 4", result, 32'hFF00_000F);
    drive(32'h7000_00F0, 32'd4, 3'b101, 1'b1, 1'b0, 1'b0);
    chk("R8 sra positive", result, 32'h0700_000F);
    drive(32'h8000_0000, 32'd4, 3'b101, 1'b0, 1'b1, 1'b1);
    chk("R8 srl raw shamt", result, 32'h0800_0000);
  endtask

  task automatic t_logic;
    drive(32'hF0F0_1234, 32'hFF00_FF00, 3'b100, 1'b0, 1'b0, 1'b0);
    chk("R9 xor", result, 32'h0FF0_ED34);
    drive(32'hF0F0_1234, 32'hFF00_FF00, 3'b110, 1'b0, 1'b0, 1'b0);
    chk("R9 or", result, 32'hFFF0_FF34);
    drive(32'hF0F0_1234, 32'hFF00_FF00, 3'b111, 1'b1, 1'b0, 1'b1);
    chk("R9 and", result, 32'hF000_1200);
    drive(32'hF0F0_1234, 32'hFF00_FF00, 3'b111, 1'b0, 1'b1, 1'b0);
    chk("R2 and inverted", result, 32'h00F0_0034);
    drive(32'hF0F0_1234, 32'hFF00_FF00, 3'b100, 1'b0, 1'b1, 1'b0);
    chk("R2 xor inverted", result, 32'hF00F_12CB);
    drive(32'h0F0F_0F0F, 32'hF0F0_F0F0, 3'b111, 1'b0, 1'b0, 1'b0);
    chk("R10 and zero", {31'h0, zero}, 32'h1);
  endtask

  initial begin
    a = '0; b = '0; op = '0; alt = 1'b0; inv = 1'b0; add1 = 1'b0;
    t_idle();
    t_add();
    t_sub();
    t_cmp();
    t_shift();
    t_logic();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule